// File: doc/BRIEF.md
# Substrate Shutter Pulse Scheduler

This block sets the exposure of an interline image sensor without changing the frame rate. It places one short clear pulse, which drains the photodiodes through the substrate, into a single horizontal retrace interval of each frame. Integration then runs from the end of that pulse to the next vertical frame-transfer pulse. Exposure therefore comes in whole lines: the block selects which retrace interval receives the pulse, counting back from the frame-transfer line.

The readout sequencer supplies three markers: a one-cycle frame-transfer marker, which also starts a frame; a one-cycle line-start marker for every other line; and a level that is high while the horizontal register is idle in retrace. The exposure in lines is sampled only on the frame-transfer marker, so a change takes effect at the next frame boundary. The block drives a logic-level strobe to the high-voltage substrate driver. It also reports whether shuttering is active in the current frame, and it raises a sticky flag if its own pulse limit ever has to cut the strobe.

Top module: `shutter_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `shutter_o`, `active_o` and `wd_err_o` are all low.
- R2: `exp_lines_i` is sampled only in a cycle where `xfer_i` is high. A change at any other time has no effect on `active_o` or on pulse placement until the next `xfer_i`.
- R3: Lines are numbered from 0. The line that begins with `xfer_i` is line 0, and each `line_start_i` advances the number by one, wrapping modulo `LINES`. For a sampled exposure E, the pulse falls only in the retrace of line `LINES - E`.
- R4: Within the chosen line, the strobe rises after `DELAY_CYC` retrace cycles have elapsed (`DELAY_CYC` ≥ 1). It stays high for `WIDTH_CYC` cycles, and it fires at most once per line.
- R5: `shutter_o` is never high while `retrace_i` is low or `xfer_i` is high. If retrace ends early, the pulse is truncated.
- R6: An exposure of 0, or of `LINES` or more, disables shuttering for that frame: `active_o` is low and no pulse is issued.
- R7: `active_o` is high exactly during frames whose sampled exposure lies in 1..`LINES`-1. It is low after reset until the first `xfer_i`.
- R8: `shutter_o` never stays high for more than `MAX_CYC` consecutive cycles. On reaching the limit the strobe is forced low for the rest of that line, and `wd_err_o` is set and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start_i | input | 1 | One-cycle marker at the start of every line except the frame-transfer line |
| retrace_i | input | 1 | High while the horizontal register is in retrace (not reading out) |
| xfer_i | input | 1 | One-cycle vertical frame-transfer marker; starts line 0 |
| exp_lines_i | input | EXPW | Requested exposure in lines |
| shutter_o | output | 1 | Logic-level substrate clear strobe |
| active_o | output | 1 | Shuttering enabled for the current frame |
| wd_err_o | output | 1 | Sticky flag: strobe was cut by the pulse-length limit |

## Verification
The assertions assume that the markers are single-cycle pulses, that `xfer_i` and `line_start_i` are never high together, and that `retrace_i` is low in marker cycles. They also assume `DELAY_CYC` is at least one, so the pulse never rises in the first retrace cycle. The stimulus builds every line as one marker cycle, ten readout cycles and then a retrace run, so all of these hold by construction. A second instance, whose pulse width exceeds its limit, drives the same inputs so that the cut-off path is exercised. Lines with shortened retrace cover truncation, and exposures of 0, `LINES` and `LINES`-1 cover the edges of the valid range.

// File: rtl/shutter_sched.sv
module shutter_sched #(
  parameter int LINES     = 525,
  parameter int EXPW      = 10,
  parameter int DELAY_CYC = 10,
  parameter int WIDTH_CYC = 45,
  parameter int MAX_CYC   = 1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_start_i,
  input  logic            retrace_i,
  input  logic            xfer_i,
  input  logic [EXPW-1:0] exp_lines_i,
  output logic            shutter_o,
  output logic            active_o,
  output logic            wd_err_o
);
  localparam int LW   = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int CMAX = DELAY_CYC + WIDTH_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int WW   = $clog2(MAX_CYC + 1);

  logic [LW-1:0]   line_q;
  logic [EXPW-1:0] exp_q;
  logic            en_q;
  logic [CW-1:0]   cnt_q;
  logic            killed_q;
  logic [WW-1:0]   wd_q;
  logic            err_q;

  wire            exp_ok = (exp_lines_i != '0) && (32'(exp_lines_i) < LINES);
  wire [LW-1:0]   target = LW'(LINES - 32'(exp_q));
  wire            hit    = en_q && (line_q == target);
  wire            in_win = (32'(cnt_q) >= DELAY_CYC) && (32'(cnt_q) < CMAX);
  wire            raw    = hit && retrace_i && !xfer_i && in_win && !killed_q;
  wire            trip   = raw && (32'(wd_q) >= MAX_CYC);

  assign shutter_o = raw && (32'(wd_q) < MAX_CYC);
  assign active_o  = en_q;
  assign wd_err_o  = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q   <= '0;
      exp_q    <= '0;
      en_q     <= 1'b0;
      cnt_q    <= '0;
      killed_q <= 1'b0;
      wd_q     <= '0;
      err_q    <= 1'b0;
    end else begin
      if (trip) err_q <= 1'b1;
      if (xfer_i) begin
        line_q   <= '0;
        cnt_q    <= '0;
        exp_q    <= exp_lines_i;
        en_q     <= exp_ok;
        killed_q <= 1'b0;
        wd_q     <= '0;
      end else if (line_start_i) begin
        line_q   <= (32'(line_q) == LINES - 1) ? '0 : line_q + 1'b1;
        cnt_q    <= '0;
        killed_q <= 1'b0;
        wd_q     <= '0;
      end else begin
        if (retrace_i && 32'(cnt_q) != CMAX) cnt_q <= cnt_q + 1'b1;
        wd_q <= shutter_o ? wd_q + 1'b1 : '0;
        if (trip) killed_q <= 1'b1;
      end
    end
  end

  p_retrace_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shutter_o |-> (retrace_i && !xfer_i));
  p_quiet_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |-> !shutter_o);
  p_frame_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_i |=> $stable(active_o));
  p_delayed_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutter_o) |-> $past(retrace_i));
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wd_err_o |=> wd_err_o);
endmodule

// File: tb/shutter_sched_tb.sv
module shutter_ref #(
  parameter int LINES = 20,
  parameter int DLY   = 3,
  parameter int WID   = 5,
  parameter int LIM   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_start,
  input  logic       retrace,
  input  logic       xfer,
  input  logic [9:0] exp_in,
  output logic       sh,
  output logic       act,
  output logic       err
);
  int line = 0, cnt = 0, e = 0, wd = 0;
  bit en = 0, killed = 0, err_r = 0;
  logic raw;

  always_comb begin
    raw = en && (line == LINES - e) && retrace && !xfer &&
          cnt >= DLY && cnt < DLY + WID && !killed;
    sh  = raw && (wd < LIM);
  end
  assign act = en;
  assign err = err_r;

  always @(posedge clk) begin
    bit trip, s;
    if (!rst_n) begin
      line = 0; cnt = 0; e = 0; wd = 0; en = 0; killed = 0; err_r = 0;
    end else begin
      trip = raw && (wd >= LIM);
      s = sh;
      if (trip) err_r = 1;
      if (xfer) begin
        line = 0; cnt = 0; e = int'(exp_in);
        en = (e != 0) && (e < LINES); killed = 0; wd = 0;
      end else if (line_start) begin
        line = (line + 1) % LINES; cnt = 0; killed = 0; wd = 0;
      end else begin
        if (retrace && cnt < DLY + WID) cnt = cnt + 1;
        wd = s ? wd + 1 : 0;
        if (trip) killed = 1;
      end
    end
  end
endmodule

module shutter_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 20, D = 3, W = 5, M = 8;
  localparam int WD_W = 10, WD_M = 6;

  logic clk = 0, rst_n = 0, line_start = 0, retrace = 0, xfer = 0;
  logic [9:0] exp_in = '0;
  logic sh, act, err, sh2, act2, err2;
  logic r_sh, r_act, r_err, r_sh2, r_act2, r_err2;

  int compared = 0, mismatched = 0, cycles = 0;
  int cur_line = 0, pcount = 0, first_line = -1;
  bit multi = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shutter_sched #(.LINES(NL), .EXPW(10), .DELAY_CYC(D), .WIDTH_CYC(W), .MAX_CYC(M)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_start_i(line_start), .retrace_i(retrace),
    .xfer_i(xfer), .exp_lines_i(exp_in), .shutter_o(sh), .active_o(act), .wd_err_o(err));
  shutter_sched #(.LINES(NL), .EXPW(10), .DELAY_CYC(D), .WIDTH_CYC(WD_W), .MAX_CYC(WD_M)) u_dut_wd (
    .clk(clk), .rst_n(rst_n), .line_start_i(line_start), .retrace_i(retrace),
    .xfer_i(xfer), .exp_lines_i(exp_in), .shutter_o(sh2), .active_o(act2), .wd_err_o(err2));

  shutter_ref #(.LINES(NL), .DLY(D), .WID(W), .LIM(M)) u_ref (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .retrace(retrace), .xfer(xfer),
    .exp_in(exp_in), .sh(r_sh), .act(r_act), .err(r_err));
  shutter_ref #(.LINES(NL), .DLY(D), .WID(WD_W), .LIM(WD_M)) u_ref_wd (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .retrace(retrace), .xfer(xfer),
    .exp_in(exp_in), .sh(r_sh2), .act(r_act2), .err(r_err2));

  task automatic check(string req, int actual, int expected, string what);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, actual, expected, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R5", sh, r_sh, "strobe vs model");
      check("R7", act, r_act, "active vs model");
      check("R8", err, r_err, "error vs model");
      check("R8", sh2, r_sh2, "limited strobe vs model");
      check("R8", err2, r_err2, "limited error vs model");
      if (sh) begin
        if (pcount == 0) first_line = cur_line;
        else if (first_line != cur_line) multi = 1;
        pcount++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cycles);
      finish_run();
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic one_line(bit is_xfer, int rt);
    xfer = is_xfer; line_start = !is_xfer;
    if (is_xfer) cur_line = 0; else cur_line = (cur_line + 1) % NL;
    tick();
    xfer = 0; line_start = 0;
    repeat (10) tick();
    retrace = 1;
    repeat (rt) tick();
    retrace = 0;
  endtask

  // R3 R4 R6 R7: one frame with exposure e; optional mid-frame change (R2) and short retrace line (R5)
  task automatic run_frame(int e, int mid_e, int short_line, int short_rt,
                           int exp_line, int exp_w);
    exp_in = 10'(e);
    pcount = 0; first_line = -1; multi = 0;
    for (int l = 0; l < NL; l++) begin
      if (l == 5 && mid_e >= 0) exp_in = 10'(mid_e);
      one_line(l == 0, (l == short_line) ? short_rt : 12);
      if (l == 2) check((e == 0 || e >= NL) ? "R6" : "R7", act,
                        (e != 0 && e < NL) ? 1 : 0, "active flag mid-frame");
    end
    if (exp_line < 0) check("R6", pcount, 0, "pulse cycles in disabled frame");
    else begin
      check("R3", first_line, exp_line, "pulse line");
      check("R4", pcount, exp_w, "pulse width");
      check("R4", int'(multi), 0, "pulse spans more than one line");
    end
  endtask

  initial begin
    repeat (3) tick();
    check("R1", sh, 0, "strobe in reset");
    check("R1", act, 0, "active in reset");
    check("R1", err, 0, "error in reset");
    rst_n = 1;
    @(negedge clk);
    check("R1", sh + act + err, 0, "outputs after reset release");
    exp_in = 10'd5;
    pcount = 0;
    for (int l = 0; l < 3; l++) one_line(0, 12);
    check("R7", act, 0, "active before first frame transfer");
    check("R7", pcount, 0, "pulses before first frame transfer");
    run_frame(5, 8, -1, 0, NL - 5, W);
    check("R8", err2, 1, "limit trip flagged");
    check("R8", err, 0, "no trip on normal width");
    run_frame(8, -1, -1, 0, NL - 8, W);
    run_frame(0, -1, -1, 0, -1, 0);
    run_frame(NL, -1, -1, 0, -1, 0);
    run_frame(NL - 1, -1, -1, 0, 1, W);
    run_frame(1, -1, NL - 1, 5, NL - 1, 2);
    tick();
    check("R8", err2, 1, "limit flag sticky");
    finish_run();
  end
endmodule